// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked core and an external 64K-word by 16-bit asynchronous static RAM. The core issues single-word requests with a request/ready handshake. Each request carries an address, write data, a two-bit byte mask and a write flag. The controller turns each request into the active-low strobe sequence the memory expects. Read results come back on a registered data port, marked by a one-cycle valid pulse.

Every phase length is a whole number of clock cycles, set by a parameter. The memory's minimum pulse widths, setup, hold and bus-release times are each rounded up to whole cycles to give these counts. The defaults suit a 100 MHz clock.

The data bus is split into three ports: an output, an input and a tristate enable. The controller turns its driver on only while output enable is high and a write phase is under way. A turnaround phase follows every access, so the memory and the controller never drive the bus at the same moment.

After reset, the controller holds off all traffic for a power-up wait before it first raises ready.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and during the start-up wait, chip, output and write enables and both byte enables stay high and the bus driver stays off. Ready is first high in the cycle after the PWRUP_CYC-th rising clock edge following reset release.
- R2: A read holds chip enable and output enable low, with write enable high, for exactly RD_CYC cycles. Byte-mask bit 0 lowers the lower byte enable (data bits 7:0) and bit 1 lowers the upper byte enable (bits 15:8).
- R3: Read data is captured on the last read-strobe cycle. rvalid is high for exactly the one cycle that follows, and rdata then holds the selected bytes, with every unselected byte reading as zero.
- R4: A write runs as three phases:
  - a setup cycle with chip enable and the selected byte enables low, write enable high, and the bus driven;
  - WR_CYC cycles with write enable low;
  - one hold cycle with write enable high while address and data are still driven.
- R5: A write changes only the bytes selected by the mask. The other byte of the word keeps its old content.
- R6: The bus driver is never on while output enable is low, and output enable and write enable are never low together.
- R7: After each strobe sequence there are TA_CYC cycles with chip and output enables high and the driver off. Ready is low from acceptance until those cycles end: RD_CYC+TA_CYC cycles for a read and WR_CYC+2+TA_CYC cycles for a write.
- R8: A request whose byte mask is 0 produces no strobe activity and no rvalid. Ready is low for exactly one cycle.
- R9: The memory address stays equal to the accepted request address on every cycle that chip enable is low.
- R10: A request presented while ready is low is ignored. It changes neither the memory contents nor the address of the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Request valid |
| ready | output | 1 | Controller idle and able to accept a request |
| addr | input | AW | Request word address |
| wdata | input | 16 | Request write data |
| bmask | input | 2 | Byte select; bit 1 = upper byte, bit 0 = lower byte |
| wr | input | 1 | 1 = write, 0 = read |
| rdata | output | 16 | Registered read data |
| rvalid | output | 1 | One-cycle read-data valid pulse |
| mem_a | output | AW | Memory address |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_ub_n | output | 1 | Memory upper byte enable, active low |
| mem_lb_n | output | 1 | Memory lower byte enable, active low |
| mem_dq_o | output | 16 | Data toward the memory |
| mem_dq_i | input | 16 | Data from the memory |
| mem_dq_oe | output | 1 | Enable for the data-bus driver |

## Verification
Reads and writes are issued with each of the three non-zero byte masks, at addresses whose upper bits differ. This separates correct byte gating from lane swaps and from address truncation. All-ones and all-zeros words, with reads immediately after writes, show whether read capture happens on the right strobe cycle. Zero-mask requests and requests raised while the controller is busy show whether the controller leaves the memory untouched when it should. A contention monitor and strobe run-length counters in the memory model catch any mis-ordered phase.

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int AW        = 16,
  parameter int RD_CYC    = 2,
  parameter int WR_CYC    = 1,
  parameter int TA_CYC    = 1,
  parameter int PWRUP_CYC = 10000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  output logic          ready,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  input  logic [1:0]    bmask,
  input  logic          wr,
  output logic [15:0]   rdata,
  output logic          rvalid,
  output logic [AW-1:0] mem_a,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic [15:0]   mem_dq_o,
  input  logic [15:0]   mem_dq_i,
  output logic          mem_dq_oe
);
  localparam int M1   = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int M2   = (M1 > TA_CYC) ? M1 : TA_CYC;
  localparam int MAXC = (M2 > PWRUP_CYC) ? M2 : PWRUP_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_BOOT, S_IDLE, S_NOP, S_RD, S_WS, S_WP, S_WH, S_TA} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_q;
  logic [15:0]   d_q;
  logic [1:0]    m_q;
  logic          act, wphase;

  assign act       = (st == S_RD) || (st == S_WS) || (st == S_WP) || (st == S_WH);
  assign wphase    = (st == S_WS) || (st == S_WP) || (st == S_WH);
  assign ready     = (st == S_IDLE);
  assign mem_a     = a_q;
  assign mem_dq_o  = d_q;
  assign mem_ce_n  = !act;
  assign mem_oe_n  = !(st == S_RD);
  assign mem_we_n  = !(st == S_WP);
  assign mem_lb_n  = !(act && m_q[0]);
  assign mem_ub_n  = !(act && m_q[1]);
  assign mem_dq_oe = wphase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_BOOT;
      cnt    <= CW'(PWRUP_CYC - 1);
      a_q    <= '0;
      d_q    <= '0;
      m_q    <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= 1'b0;
      case (st)
        S_BOOT: if (cnt == '0) st <= S_IDLE; else cnt <= cnt - 1'b1;
        S_IDLE: if (req) begin
          a_q <= addr;
          d_q <= wdata;
          m_q <= bmask;
          if (bmask == 2'b00) st <= S_NOP;
          else if (wr) st <= S_WS;
          else begin
            st  <= S_RD;
            cnt <= CW'(RD_CYC - 1);
          end
        end
        S_NOP: st <= S_IDLE;
        S_RD: if (cnt == '0) begin
          rdata  <= {m_q[1] ? mem_dq_i[15:8] : 8'h00, m_q[0] ? mem_dq_i[7:0] : 8'h00};
          rvalid <= 1'b1;
          st     <= S_TA;
          cnt    <= CW'(TA_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_WS: begin
          st  <= S_WP;
          cnt <= CW'(WR_CYC - 1);
        end
        S_WP: if (cnt == '0) st <= S_WH; else cnt <= cnt - 1'b1;
        S_WH: begin
          st  <= S_TA;
          cnt <= CW'(TA_CYC - 1);
        end
        S_TA: if (cnt == '0) st <= S_IDLE; else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_BOOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BOOT) |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !ready)); // R1
  AST_RVALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid); // R3
  AST_WE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && (!mem_ub_n || !mem_lb_n) && mem_dq_oe)); // R4
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && $stable(mem_dq_o))); // R4
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R6
  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n)); // R6
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_ce_n && mem_oe_n && !mem_dq_oe)); // R7
  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req && bmask == 2'b00) |=> (mem_ce_n && !ready)); // R8
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_a)); // R9
endmodule

// File: tb/sim_sram_ctrl.sv
module sim_sram_ctrl;
  localparam int RD = 2, WR = 1, TA = 1, PW = 10000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, req, ready, wr, rvalid;
  logic [15:0] addr, wdata, rdata, mem_a, mem_dq_o, mem_dq_i;
  logic [1:0]  bmask;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;

  sram_ctrl #(.AW(16), .RD_CYC(RD), .WR_CYC(WR), .TA_CYC(TA), .PWRUP_CYC(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .addr(addr), .wdata(wdata),
    .bmask(bmask), .wr(wr), .rdata(rdata), .rvalid(rvalid), .mem_a(mem_a),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n),
    .mem_lb_n(mem_lb_n), .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i), .mem_dq_oe(mem_dq_oe));

  logic [15:0] marr [256];
  logic [15:0] shadow [256];
  logic [15:0] exp_q [$];
  logic [15:0] cur_addr;
  int nchk = 0, nerr = 0, mchk = 0, merr = 0, ce_total = 0;
  int oe_run = 0, we_run = 0;

  wire mdrv = !mem_ce_n && !mem_oe_n && mem_we_n && (!mem_ub_n || !mem_lb_n);
  assign mem_dq_i = mdrv ? {mem_ub_n ? 8'hEE : marr[mem_a[7:0]][15:8],
                            mem_lb_n ? 8'hEE : marr[mem_a[7:0]][7:0]}
                         : (mem_dq_oe ? mem_dq_o : 16'h5A5A);

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n) ce_total <= ce_total + 1;
      if (mdrv && mem_dq_oe) begin
        mchk++; merr++;
        $display("FAIL R6 bus contention: dq_oe=%0d expected 0 while memory drives", mem_dq_oe);
      end
      if (!mem_ce_n && mem_a != cur_addr) begin
        mchk++; merr++;
        $display("FAIL R9 address moved: %h expected %h", mem_a, cur_addr);
      end
      if (!mem_ce_n && !mem_we_n && (!mem_ub_n || !mem_lb_n)) begin
        if (!mem_dq_oe) begin
          mchk++; merr++;
          $display("FAIL R4 write with bus undriven: dq_oe=%0d expected 1", mem_dq_oe);
        end
        if (!mem_ub_n) marr[mem_a[7:0]][15:8] <= mem_dq_o[15:8];
        if (!mem_lb_n) marr[mem_a[7:0]][7:0]  <= mem_dq_o[7:0];
      end
      if (!mem_oe_n) oe_run <= oe_run + 1;
      else if (oe_run > 0) begin
        mchk++;
        if (oe_run != RD) begin
          merr++;
          $display("FAIL R2 read strobe length %0d expected %0d", oe_run, RD);
        end
        oe_run <= 0;
      end
      if (!mem_we_n) we_run <= we_run + 1;
      else if (we_run > 0) begin
        mchk++;
        if (we_run != WR) begin
          merr++;
          $display("FAIL R4 write pulse length %0d expected %0d", we_run, WR);
        end
        we_run <= 0;
      end
      if (rvalid) begin
        mchk++;
        if (exp_q.size() == 0) begin
          merr++;
          $display("FAIL R3/R8 unexpected rvalid: rdata=%h expected no pulse", rdata);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          if (rdata !== e) begin
            merr++;
            $display("FAIL R3 read data %h expected %h", rdata, e);
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [15:0] a, input logic [15:0] d,
                        input logic [1:0] m, input bit poke);
    int n, ce0, explow;
    @(negedge clk);
    while (!ready) @(negedge clk);
    cur_addr = a;
    ce0 = ce_total;
    if (m != 2'b00) begin
      if (w) begin
        if (m[1]) shadow[a[7:0]][15:8] = d[15:8];
        if (m[0]) shadow[a[7:0]][7:0]  = d[7:0];
      end else
        exp_q.push_back({m[1] ? shadow[a[7:0]][15:8] : 8'h00, m[0] ? shadow[a[7:0]][7:0] : 8'h00});
    end
    wr = w; addr = a; wdata = d; bmask = m; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    n = 0;
    while (!ready) begin
      n++;
      if (poke && n == 1) begin
        req = 1'b1; wr = 1'b1; addr = a ^ 16'h0001; wdata = 16'hDEAD; bmask = 2'b11;
      end
      if (poke && n == 2) req = 1'b0;
      if (!w && m != 2'b00 && n == RD + 1) chk(rvalid === 1'b1, "R3 rvalid timing", rvalid, 1);
      @(negedge clk);
    end
    explow = (m == 2'b00) ? 1 : (w ? WR + 2 + TA : RD + TA);
    chk(n == explow, (m == 2'b00) ? "R8 busy cycles" : "R7 busy cycles", n, explow);
    if (m == 2'b00) chk(ce_total == ce0, "R8 strobe activity", ce_total - ce0, 0);
  endtask

  initial begin
    int low;
    for (int i = 0; i < 256; i++) begin
      marr[i]   = 16'(i * 16'h0101) ^ 16'h3C3C;
      shadow[i] = 16'(i * 16'h0101) ^ 16'h3C3C;
    end
    cur_addr = 16'h0; rst_n = 1'b0; req = 1'b0; wr = 1'b0;
    addr = 16'h0; wdata = 16'h0; bmask = 2'b00;
    repeat (4) @(negedge clk);
    chk({mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, ready} == 7'b1111100,
        "R1 reset outputs", {mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, ready}, 7'b1111100);
    rst_n = 1'b1;
    low = 0;
    @(negedge clk);
    while (!ready) begin
      if (!mem_ce_n || mem_dq_oe) chk(0, "R1 strobe during wait", mem_ce_n, 1);
      low++;
      @(negedge clk);
    end
    chk(low == PW - 1, "R1 start-up wait", low, PW - 1);

    access(0, 16'h0010, 16'h0, 2'b11, 0);     // R2 R3 initial content
    access(1, 16'h0010, 16'h1234, 2'b11, 0);  // R4
    access(0, 16'h0010, 16'h0, 2'b11, 0);
    access(1, 16'hFF21, 16'hABCD, 2'b01, 0);  // R5 lower only
    access(0, 16'hFF21, 16'h0, 2'b11, 0);
    access(1, 16'h8033, 16'h5678, 2'b10, 0);  // R5 upper only
    access(0, 16'h8033, 16'h0, 2'b11, 0);
    access(0, 16'h0010, 16'h0, 2'b01, 0);     // R3 unselected byte zero
    access(0, 16'h0010, 16'h0, 2'b10, 0);
    access(1, 16'h4044, 16'hFFFF, 2'b11, 0);
    access(0, 16'h4044, 16'h0, 2'b11, 0);
    access(1, 16'h4044, 16'h0000, 2'b11, 0);
    access(0, 16'h4044, 16'h0, 2'b11, 0);
    access(1, 16'h0055, 16'h9999, 2'b00, 0);  // R8 zero-mask write
    access(0, 16'h0055, 16'h0, 2'b00, 0);     // R8 zero-mask read
    access(0, 16'h0055, 16'h0, 2'b11, 0);     // R8 memory unchanged
    access(0, 16'h2066, 16'h0, 2'b11, 1);     // R10 poke while busy
    access(0, 16'h2067, 16'h0, 2'b11, 0);     // R10 poked address unchanged
    access(0, 16'hC077, 16'h0, 2'b11, 0);     // back-to-back reads
    access(0, 16'hC078, 16'h0, 2'b11, 0);
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R3 outstanding reads", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk + mchk, nerr + merr);
    $finish;
  end

  initial begin
    #(8 * 150000);
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk + mchk + 1, nerr + merr + 1);
    $finish;
  end
endmodule